// File: doc/BRIEF.md
# Status Ring Descriptor Producer

This block sits behind a table-search / cache-control engine. Each completion record it accepts becomes one status descriptor of eight 32-bit words. It writes those words, one word per cycle, into a circular ring held in a word-addressed memory. Descriptor slot `h` occupies memory words `8*h` to `8*h+7`. Once the eighth word is written, the head pointer moves on by one slot.

Every descriptor carries a ring identifier and a 4-bit pass stamp. The stamp is 1 throughout the first trip around the ring and goes up by one each time the head wraps. A consumer can therefore tell fresh slots from stale ones by reading only the stamp, or only its lowest bit, and never needs the head pointer for that. The consumer reports its position on a tail pointer input. The producer stops accepting records when one more entry would make the head meet the tail.

Top module: `stsring_producer`

## Requirements
- R1: After reset the head pointer is 0, no memory write is issued and `in_ready` is high (given a tail of 0 and a ring of at least 2 entries).
- R2: A descriptor accepted at head slot h is written as 8 writes on 8 consecutive cycles, to addresses 8*h+0 through 8*h+7 in rising order, starting the cycle after acceptance.
- R3: Word 0 is {entry count[31:8], index-mode flag[7], result code[6:5], engine select[4], operation code[3:0]}. Result codes are 0 success, 1 not found and 2 timeout.
- R4: The entry count (word 0 bits 31:8), the byte count (word 1) and the timestamp (word 2) carry the input values only for operation codes 7 and 8. For every other code they are written as zero.
- R5: Word 3 is metadata bits 31:0 and word 4 is metadata bits 63:32, both unchanged.
- R6: Word 5 is {8'h00, cache set[23:20], hash index[19:0]}. The hash index is written only when the result code is 1 or the operation code is 1, and is zero otherwise. Word 6 is all zero.
- R7: Word 7 is {pass stamp[31:28], ring ID[27:20], 20'h0}. The ring ID is the configuration value captured when the record is accepted.
- R8: The pass stamp is 1 for descriptors written before the first head wrap. It increments by one at each wrap and rolls over from 15 to 0.
- R9: When the slot after the head (wrapping at the configured entry count) equals the tail input, `in_ready` is low and no record is accepted.
- R10: The head pointer stays unchanged while a descriptor is being written. It advances by one in the cycle after the eighth word, and goes to 0 instead of reaching the configured entry count.
- R11: `in_ready` is low from acceptance until the last word of that descriptor has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Completion record offered |
| in_ready | output | 1 | Record accepted on this edge when valid |
| in_opcode | input | 4 | Operation code |
| in_engine | input | 1 | Engine select (0 address, 1 flow) |
| in_result | input | 2 | Result code |
| in_index_mode | input | 1 | Index-based command flag |
| in_entry_cnt | input | 24 | Entry count statistic |
| in_byte_cnt | input | 32 | Byte count statistic |
| in_tstamp | input | 32 | Timestamp statistic |
| in_meta | input | 64 | Command metadata |
| in_hash | input | 20 | Hash index |
| in_set | input | 4 | Cache set number |
| cfg_entries | input | PTR_W+1 | Ring size in descriptors (2 to 2^PTR_W) |
| cfg_ring_id | input | 8 | Ring identifier |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | PTR_W+3 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| head_ptr | output | PTR_W | Producer head slot |
| tail_ptr | input | PTR_W | Consumer tail slot |

## Verification
Records are sent with operation codes 7 and 8 and with an ordinary cache code whose statistic inputs are non-zero, which shows whether the statistics gating keys on the code. Results of success, not found and timeout, combined with the search-disabled code, show whether the hash is written only when the search failed or was off. A four-entry ring is filled until the head sits one slot behind the tail, which shows whether the full test blocks a held request. Releasing the tail then wraps the head. A two-entry ring is then run through seventeen wraps, which shows whether the stamp starts at 1, steps once per wrap and rolls over from 15 to 0.

// File: rtl/stsring_pkg.sv
package stsring_pkg;

  localparam int DESC_WORDS = 8;
  localparam int WIDX_W     = $clog2(DESC_WORDS);
  localparam int STAMP_W    = 4;

  typedef enum logic [3:0] {
    OP_READ_STATS  = 4'd0,
    OP_SEARCH_OFF  = 4'd1,
    OP_FLUSH_INVAL = 4'd7,
    OP_CLEAR_STATS = 4'd8
  } opcode_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_MISSING = 2'd1,
    RES_TIMEOUT = 2'd2
  } result_e;

  typedef struct packed {
    logic [3:0]  op;
    logic        engine;
    logic [1:0]  result;
    logic        index_mode;
    logic [23:0] entry_cnt;
    logic [31:0] byte_cnt;
    logic [31:0] tstamp;
    logic [63:0] meta;
    logic [19:0] hash;
    logic [3:0]  cset;
    logic [7:0]  ring_id;
  } cmpl_t;

  // statistic fields only mean something for these two codes
  function automatic logic stats_live(input logic [3:0] op);
    return (op == OP_FLUSH_INVAL) || (op == OP_CLEAR_STATS);
  endfunction

  // hash is reported when the lookup missed or lookup was turned off
  function automatic logic hash_live(input logic [3:0] op, input logic [1:0] res);
    return (res == RES_MISSING) || (op == OP_SEARCH_OFF);
  endfunction

  // pass stamp seen by the consumer: one ahead of the completed-wrap count
  function automatic logic [STAMP_W-1:0] stamp_of(input logic [STAMP_W-1:0] wraps);
    return wraps + 1'b1;
  endfunction

  function automatic logic [31:0] desc_word(input cmpl_t r,
                                            input logic [WIDX_W-1:0] idx,
                                            input logic [STAMP_W-1:0] stamp);
    logic        sl;
    logic [31:0] w;
    sl = stats_live(r.op);
    case (idx)
      3'd0:    w = {(sl ? r.entry_cnt : 24'h0), r.index_mode, r.result, r.engine, r.op};
      3'd1:    w = sl ? r.byte_cnt : 32'h0;
      3'd2:    w = sl ? r.tstamp : 32'h0;
      3'd3:    w = r.meta[31:0];
      3'd4:    w = r.meta[63:32];
      3'd5:    w = {8'h00, r.cset, (hash_live(r.op, r.result) ? r.hash : 20'h0)};
      3'd7:    w = {stamp, r.ring_id, 20'h0};
      default: w = 32'h0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/stsring_seq.sv
module stsring_seq
  import stsring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              ring_full,
  output logic              in_ready,
  output logic              accept,
  output logic              busy,
  output logic [WIDX_W-1:0] widx,
  output logic              last_word
);

  logic              busy_q;
  logic [WIDX_W-1:0] widx_q;

  assign busy      = busy_q;
  assign widx      = widx_q;
  assign in_ready  = !busy_q && !ring_full;
  assign accept    = in_valid && in_ready;
  assign last_word = busy_q && (widx_q == WIDX_W'(DESC_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      widx_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      widx_q <= '0;
    end else if (busy_q) begin
      widx_q <= widx_q + 1'b1;
      if (last_word) busy_q <= 1'b0;
    end
  end

  AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_word) |=> (busy_q && widx_q == $past(widx_q) + 1'b1)); // R2

endmodule

// File: rtl/stsring_ptr.sv
module stsring_ptr
  import stsring_pkg::*;
#(
  parameter int PTR_W = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PTR_W:0]     cfg_entries,
  input  logic [PTR_W-1:0]   tail,
  input  logic               step,
  output logic [PTR_W-1:0]   head,
  output logic [STAMP_W-1:0] wraps,
  output logic               ring_full,
  output logic               wrap_evt
);

  logic [PTR_W-1:0]   head_q;
  logic [STAMP_W-1:0] wraps_q;
  logic [PTR_W:0]     head_inc;
  logic [PTR_W-1:0]   head_nx;

  assign head_inc  = {1'b0, head_q} + 1'b1;
  assign wrap_evt  = (head_inc == cfg_entries);
  assign head_nx   = wrap_evt ? '0 : head_inc[PTR_W-1:0];
  assign ring_full = (head_nx == tail);
  assign head      = head_q;
  assign wraps     = wraps_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      wraps_q <= '0;
    end else if (step) begin
      head_q <= head_nx;
      if (wrap_evt) wraps_q <= wraps_q + 1'b1;
    end
  end

  AST_PASS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wraps_q != $past(wraps_q)) |-> (head_q == '0)); // R8

endmodule

// File: rtl/stsring_fmt.sv
module stsring_fmt
  import stsring_pkg::*;
(
  input  cmpl_t              rec,
  input  logic [WIDX_W-1:0]  widx,
  input  logic [STAMP_W-1:0] wraps,
  output logic [31:0]        word
);

  logic [31:0] lane [DESC_WORDS];

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_lane
    assign lane[g] = desc_word(rec, WIDX_W'(g), stamp_of(wraps));
  end

  assign word = lane[widx];

endmodule

// File: rtl/stsring_producer.sv
module stsring_producer
  import stsring_pkg::*;
#(
  parameter int PTR_W  = 8,
  localparam int ADDR_W = PTR_W + WIDX_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_opcode,
  input  logic              in_engine,
  input  logic [1:0]        in_result,
  input  logic              in_index_mode,
  input  logic [23:0]       in_entry_cnt,
  input  logic [31:0]       in_byte_cnt,
  input  logic [31:0]       in_tstamp,
  input  logic [63:0]       in_meta,
  input  logic [19:0]       in_hash,
  input  logic [3:0]        in_set,
  input  logic [PTR_W:0]    cfg_entries,
  input  logic [7:0]        cfg_ring_id,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [PTR_W-1:0]  head_ptr,
  input  logic [PTR_W-1:0]  tail_ptr
);

  logic               ring_full;
  logic               accept;
  logic               busy;
  logic               last_word;
  logic               wrap_evt;
  logic [WIDX_W-1:0]  widx;
  logic [STAMP_W-1:0] wraps;
  cmpl_t              rec_q;
  cmpl_t              rec_in;

  assign rec_in = '{op: in_opcode, engine: in_engine, result: in_result,
                    index_mode: in_index_mode, entry_cnt: in_entry_cnt,
                    byte_cnt: in_byte_cnt, tstamp: in_tstamp, meta: in_meta,
                    hash: in_hash, cset: in_set, ring_id: cfg_ring_id};

  always_ff @(posedge clk) begin
    if (!rst_n) rec_q <= '0;
    else if (accept) rec_q <= rec_in;
  end

  stsring_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ring_full(ring_full),
    .in_ready(in_ready), .accept(accept), .busy(busy), .widx(widx),
    .last_word(last_word)
  );

  stsring_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cfg_entries(cfg_entries), .tail(tail_ptr),
    .step(last_word), .head(head_ptr), .wraps(wraps), .ring_full(ring_full),
    .wrap_evt(wrap_evt)
  );

  stsring_fmt u_fmt (
    .rec(rec_q), .widx(widx), .wraps(wraps), .word(mem_wdata)
  );

  assign mem_we   = busy;
  assign mem_addr = {head_ptr, widx};

  AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> !ring_full); // R9

  AST_BURST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && widx != '0) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R2

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && widx == WIDX_W'(6)) |-> (mem_wdata == 32'h0)); // R6

  AST_STATS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && widx == WIDX_W'(1) && !stats_live(rec_q.op)) |-> (mem_wdata == 32'h0)); // R4

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (head_ptr != $past(head_ptr)) |-> $past(mem_we && widx == WIDX_W'(DESC_WORDS - 1))); // R10

  AST_WRITE_NOREADY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_ready); // R11

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (last_word && wrap_evt) |=> (head_ptr == '0)); // R10

endmodule

// File: tb/tb_stsring_producer.sv
module tb_stsring_producer;

  localparam int PTR_W = 8;
  localparam int AW    = PTR_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0]  in_opcode = '0;
  logic        in_engine = 1'b0;
  logic [1:0]  in_result = '0;
  logic        in_index_mode = 1'b0;
  logic [23:0] in_entry_cnt = '0;
  logic [31:0] in_byte_cnt = '0;
  logic [31:0] in_tstamp = '0;
  logic [63:0] in_meta = '0;
  logic [19:0] in_hash = '0;
  logic [3:0]  in_set = '0;
  logic [PTR_W:0] cfg_entries = 9'd4;
  logic [7:0]  cfg_ring_id = 8'h5A;
  logic        mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [PTR_W-1:0] head_ptr;
  logic [PTR_W-1:0] tail_ptr = '0;

  always #2.5 clk = ~clk;

  stsring_producer #(.PTR_W(PTR_W)) dut (.*);

  typedef struct {
    logic [AW-1:0] a;
    logic [31:0]   d;
    int            w;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int writes_seen = 0;
  int exp_head = 0;
  int exp_wraps = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int w);
    case (w)
      0: return "R3";
      1, 2: return "R4";
      3, 4: return "R5";
      5, 6: return "R6";
      default: return "R7/R8";
    endcase
  endfunction

  // monitor: pops the scoreboard on every memory write
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      writes_seen++;
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected write addr", longint'(mem_addr), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(mem_addr == e.a, "R2", $sformatf("addr word %0d", e.w),
              longint'(mem_addr), longint'(e.a));
        check(mem_wdata == e.d, tag_of(e.w), $sformatf("data word %0d", e.w),
              longint'(mem_wdata), longint'(e.d));
      end
    end
  end

  task automatic do_reset(input int entries, input logic [7:0] rid);
    rst_n = 1'b0;
    in_valid = 1'b0;
    cfg_entries = (PTR_W+1)'(entries);
    cfg_ring_id = rid;
    tail_ptr = '0;
    q.delete();
    exp_head = 0;
    exp_wraps = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [3:0] op, input logic [1:0] res, input logic eng,
                      input logic imode, input logic [23:0] cnt, input logic [31:0] byt,
                      input logic [31:0] ts, input logic [63:0] meta,
                      input logic [19:0] hsh, input logic [3:0] cs);
    bit stats;
    bit hv;
    int stamp;
    int h0;
    logic [31:0] words [8];
    @(negedge clk);
    in_opcode = op; in_result = res; in_engine = eng; in_index_mode = imode;
    in_entry_cnt = cnt; in_byte_cnt = byt; in_tstamp = ts; in_meta = meta;
    in_hash = hsh; in_set = cs; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    stats = (op == 4'd7) || (op == 4'd8);
    hv    = (res == 2'd1) || (op == 4'd1);
    stamp = (exp_wraps + 1) % 16;
    words[0] = (stats ? (32'(cnt) << 8) : 32'h0) | (32'(imode) << 7) |
               (32'(res) << 5) | (32'(eng) << 4) | 32'(op);
    words[1] = stats ? byt : 32'h0;
    words[2] = stats ? ts : 32'h0;
    words[3] = meta[31:0];
    words[4] = meta[63:32];
    words[5] = (32'(cs) << 20) | (hv ? 32'(hsh) : 32'h0);
    words[6] = 32'h0;
    words[7] = (32'(stamp) << 28) | (32'(cfg_ring_id) << 20);
    for (int k = 0; k < 8; k++) begin
      exp_t e;
      e.a = AW'(exp_head * 8 + k);
      e.d = words[k];
      e.w = k;
      q.push_back(e);
    end
    h0 = exp_head;
    exp_head = exp_head + 1;
    if (exp_head == int'(cfg_entries)) begin
      exp_head = 0;
      exp_wraps = (exp_wraps + 1) % 16;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(head_ptr) == h0, "R10", "head mid-write", longint'(head_ptr), h0);
    check(in_ready == 1'b0, "R11", "ready mid-write", longint'(in_ready), 0);
    repeat (5) @(negedge clk);
    check(int'(head_ptr) == exp_head, "R10", "head after write", longint'(head_ptr), exp_head);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int wseen;
    do_reset(4, 8'h5A);
    check(head_ptr == '0, "R1", "head after reset", longint'(head_ptr), 0);
    check(mem_we == 1'b0, "R1", "write after reset", longint'(mem_we), 0);
    check(in_ready == 1'b1, "R1", "ready after reset", longint'(in_ready), 1);

    // tail held at 0: three slots may fill before the ring is full
    send(4'd7, 2'd0, 1'b1, 1'b1, 24'hABCDEF, 32'h1234_5678, 32'h9ABC_DEF0,
         64'h0123_4567_89AB_CDEF, 20'hFFFFF, 4'hA);          // R3 R4, hash gated (R6)
    send(4'd8, 2'd1, 1'b0, 1'b0, 24'h000001, 32'hFFFF_FFFF, 32'h0000_0001,
         64'hDEAD_BEEF_CAFE_F00D, 20'h12345, 4'h3);          // R6 hash on miss
    send(4'd3, 2'd0, 1'b1, 1'b0, 24'h777777, 32'h5555_5555, 32'hAAAA_AAAA,
         64'hFFFF_0000_FFFF_0000, 20'h54321, 4'hF);          // R4 stats zeroed

    // R9: head=3, next slot 0 == tail
    @(negedge clk);
    check(in_ready == 1'b0, "R9", "ready when full", longint'(in_ready), 0);
    in_valid = 1'b1;
    wseen = writes_seen;
    repeat (10) @(negedge clk);
    check(writes_seen == wseen, "R9", "writes while full", writes_seen, wseen);
    check(int'(head_ptr) == 3, "R9", "head while full", longint'(head_ptr), 3);
    in_valid = 1'b0;
    tail_ptr = 8'd1;
    send(4'd2, 2'd2, 1'b0, 1'b1, 24'h1, 32'h2, 32'h3,
         64'h1111_2222_3333_4444, 20'hABCDE, 4'h5);          // R10 wrap to 0
    tail_ptr = 8'd0;
    send(4'd1, 2'd2, 1'b1, 1'b1, 24'h1, 32'h2, 32'h3,
         64'h5555_6666_7777_8888, 20'h0F0F0, 4'h6);          // R6 search off, R8 stamp 2

    // R8: two-entry ring, seventeen wraps to cross the 15 -> 0 rollover
    do_reset(2, 8'hC3);
    for (int n = 0; n < 34; n++) begin
      tail_ptr = PTR_W'(exp_head);
      send(4'(n % 9), 2'(n % 3), 1'(n), 1'(n >> 1), 24'(n * 3), 32'(n * 17),
           32'(n * 101), {32'(n), 32'hFEED_0000 + 32'(n)}, 20'(n * 4099), 4'(n));
    end
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2", "words left unwritten", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule